// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and a plain word-wide memory-mapped bus. Each request names a bus, a device and a function, and carries a register offset, an access size and, for writes, the data to write. The block first decides whether the target can be reached at all. Requests that cannot be reached are answered at once and never reach the bus.

For a reachable target, the block picks one of two address windows:
- Requests to the root bus go to the root port's own register space, with no translation.
- Requests to any other bus go to a configuration window. Before that access, the block loads a translation target register with the packed identifier and selects a configuration type code for the outbound window.

Every downstream access is one aligned 32-bit word. A write narrower than a word becomes a read, then a merge, then a write. A read narrower than a word returns the addressed lanes shifted down to bit 0.

The upstream side has a request handshake (`req_valid_i`/`req_ready_o`) and a one-cycle response strobe. The downstream side has a request, a write enable and an acknowledge. Only one request is handled at a time. The type code and translation target are held in registers and driven out as ports, so the outbound window logic can use them.

Top module: `cfg_xlate`

## Requirements
- R1: A request whose bus equals `root_bus_i` with a nonzero device number is unreachable. It makes no downstream access and leaves the type code and translation target unchanged. A read returns all ones of its size (byte 0xFF, halfword 0xFFFF, word 0xFFFFFFFF); a write is dropped and returns 0.
- R2: A request whose bus equals `root_bus_i`+1 with a nonzero device number is handled exactly as in R1. The +1 is computed without 8-bit wrap, so a root bus of 255 has no such neighbour bus.
- R3: For a reachable request, the type code register becomes 4 when the bus equals `root_bus_i`+1 and 5 for any other bus, including the root bus. After reset it holds 4.
- R4: A reachable request to the root bus accesses `local_base_i` plus the word-aligned offset, and leaves the translation target unchanged.
- R5: A reachable request to any other bus loads the translation target with the bus in bits 31:24, the device in bits 23:19 and the function in bits 18:16, with bits 15:0 set to zero. It then accesses `window_base_i` plus the word-aligned offset.
- R6: Every downstream address has bits 1:0 cleared. The offset's two low bits only select byte lanes.
- R7: A byte or halfword write makes one downstream read and then one write to the same address. The written word keeps the old bytes and replaces only the lanes starting at offset bits 1:0. A full-word write makes a single downstream write and no read.
- R8: Size encoding is 0 for byte, 1 for halfword and 2 for word. A byte or halfword read returns the lanes starting at offset bits 1:0, shifted down and zero-extended. A word read returns the whole word.
- R9: Only one request is in flight at a time. `req_ready_o` is low from acceptance until the response, including both halves of a read-modify-write. `rsp_valid_o` is a single-cycle pulse in the cycle after the last acknowledge, or in the cycle after acceptance for an unreachable request. The downstream address stays stable while a request is unacknowledged.
- R10: After reset, `req_ready_o` is high, `mem_req_o` and `rsp_valid_o` are low, the type code is 4 and the translation target is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_bus_i | input | 8 | Bus number of the root port |
| local_base_i | input | 32 | Base address of the root port register space |
| window_base_i | input | 32 | Base address of the outbound configuration window |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_dev_i | input | 5 | Target device number |
| req_fn_i | input | 3 | Target function number |
| req_off_i | input | 12 | Register offset in bytes |
| req_size_i | input | 2 | Access size (0 byte, 1 halfword, 2 word) |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | 32 | Read result, right-aligned; 0 for writes |
| mem_req_o | output | 1 | Downstream access request |
| mem_we_o | output | 1 | Downstream write enable |
| mem_addr_o | output | 32 | Downstream word address |
| mem_wdata_o | output | 32 | Downstream write word |
| mem_ack_i | input | 1 | Downstream access complete |
| mem_rdata_i | input | 32 | Downstream read word, valid with acknowledge |
| win_type_o | output | 3 | Outbound window configuration type code |
| win_target_o | output | 32 | Outbound window translation target |

## Verification
The main function is exercised with reads and writes of every size, aimed at three kinds of bus:
- The root bus tells the local window apart from the translated window.
- The bus just below the root tells type code 4 apart from 5.
- A far bus with nonzero device and function numbers shows each field landing at its own bit position.

Sub-word writes are each followed by a full-word read-back. This separates a correct lane merge from a plain overwrite, and an unaligned byte lane from an aligned one. Unreachable requests are placed both before and after valid ones; the translation target must keep its old value and a later read must still see the old memory word. A root bus of 255 shows whether the neighbour comparison wraps.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_RSP  = 2'd3
  } seq_state_e;

  localparam int unsigned WORD_W    = 32;
  localparam logic [2:0]  TYPE_LOCAL = 3'd4;
  localparam logic [2:0]  TYPE_FAR   = 3'd5;

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00ff;
      SZ_HALF: size_mask = 32'h0000_ffff;
      default: size_mask = 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/cfg_xlate_route.sv
module cfg_xlate_route
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned FN_W   = 3,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [BUS_W-1:0]  root_bus_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] local_base_i,
  input  logic [ADDR_W-1:0] window_base_i,
  output logic              reach_o,
  output logic              local_o,
  output logic [2:0]        type_o,
  output logic [WORD_W-1:0] target_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned ID_W  = BUS_W + DEV_W + FN_W;
  localparam int unsigned PAD_W = WORD_W - ID_W;

  logic [BUS_W:0]    next_bus;
  logic              is_root, is_next, dev_zero;
  logic [ADDR_W-1:0] off_word;

  // neighbour bus compared one bit wider so that the root bus 255 does not wrap
  assign next_bus = {1'b0, root_bus_i} + 1'b1;
  assign is_root  = (bus_i == root_bus_i);
  assign is_next  = ({1'b0, bus_i} == next_bus);
  assign dev_zero = (dev_i == '0);

  assign reach_o  = dev_zero || !(is_root || is_next);
  assign local_o  = is_root;
  assign type_o   = is_next ? TYPE_LOCAL : TYPE_FAR;
  assign target_o = {bus_i, dev_i, fn_i, {PAD_W{1'b0}}};

  assign off_word = ADDR_W'({off_i[OFF_W-1:2], 2'b00});
  assign addr_o   = (is_root ? local_base_i : window_base_i) + off_word;

endmodule

// File: rtl/cfg_xlate_lane.sv
module cfg_xlate_lane
  import cfg_xlate_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [1:0]        lane_i,
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] new_i,
  output logic [WORD_W-1:0] extract_o,
  output logic [WORD_W-1:0] merged_o
);
  localparam int unsigned NBYTE = WORD_W / 8;

  logic [WORD_W-1:0] mask, mask_sh, new_sh;
  logic [4:0]        shamt;

  assign mask    = size_mask(size_i);
  assign shamt   = size_i[1] ? 5'd0 : {lane_i, 3'b000};
  assign mask_sh = mask << shamt;
  assign new_sh  = (new_i & mask) << shamt;

  assign extract_o = (old_i >> shamt) & mask;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign merged_o[8*b +: 8] = mask_sh[8*b] ? new_sh[8*b +: 8] : old_i[8*b +: 8];
  end

endmodule

// File: rtl/cfg_xlate_seq.sv
module cfg_xlate_seq
  import cfg_xlate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic reach_i,
  input  logic write_i,
  input  logic full_i,
  input  logic wr_q_i,
  input  logic ack_i,
  output seq_state_e state_o,
  output logic ready_o,
  output logic req_o,
  output logic we_o,
  output logic rsp_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept_i) begin
        if (!reach_i)              state_d = ST_RSP;
        else if (write_i && full_i) state_d = ST_WR;
        else                       state_d = ST_RD;
      end
      ST_RD:   if (ack_i) state_d = wr_q_i ? ST_WR : ST_RSP;
      ST_WR:   if (ack_i) state_d = ST_RSP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign ready_o = (state_q == ST_IDLE);
  assign req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign we_o    = (state_q == ST_WR);
  assign rsp_o   = (state_q == ST_RSP);

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned FN_W   = 3,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  root_bus_i,
  input  logic [ADDR_W-1:0] local_base_i,
  input  logic [ADDR_W-1:0] window_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [FN_W-1:0]   req_fn_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [2:0]        win_type_o,
  output logic [31:0]       win_target_o
);
  logic              accept, reach, is_local;
  logic [2:0]        route_type;
  logic [WORD_W-1:0] route_target;
  logic [ADDR_W-1:0] route_addr;
  logic [WORD_W-1:0] lane_extract, lane_merged;
  seq_state_e        state;
  logic              seq_ready, seq_req, seq_we, seq_rsp;

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [1:0]        size_q, lane_q;
  logic [WORD_W-1:0] wdata_q, data_q;
  logic [2:0]        type_q;
  logic [WORD_W-1:0] target_q;

  assign accept = req_valid_i && seq_ready;

  cfg_xlate_route #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W)
  ) u_route (
    .root_bus_i    (root_bus_i),
    .bus_i         (req_bus_i),
    .dev_i         (req_dev_i),
    .fn_i          (req_fn_i),
    .off_i         (req_off_i),
    .local_base_i  (local_base_i),
    .window_base_i (window_base_i),
    .reach_o       (reach),
    .local_o       (is_local),
    .type_o        (route_type),
    .target_o      (route_target),
    .addr_o        (route_addr)
  );

  cfg_xlate_lane u_lane (
    .size_i    (size_q),
    .lane_i    (lane_q),
    .old_i     (mem_rdata_i),
    .new_i     (wdata_q),
    .extract_o (lane_extract),
    .merged_o  (lane_merged)
  );

  cfg_xlate_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .reach_i  (reach),
    .write_i  (req_write_i),
    .full_i   (req_size_i[1]),
    .wr_q_i   (wr_q),
    .ack_i    (mem_ack_i),
    .state_o  (state),
    .ready_o  (seq_ready),
    .req_o    (seq_req),
    .we_o     (seq_we),
    .rsp_o    (seq_rsp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wr_q     <= 1'b0;
      size_q   <= SZ_WORD;
      lane_q   <= '0;
      wdata_q  <= '0;
      data_q   <= '0;
      type_q   <= TYPE_LOCAL;
      target_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= route_addr;
        wr_q    <= req_write_i;
        size_q  <= req_size_i;
        lane_q  <= req_off_i[1:0];
        wdata_q <= req_wdata_i;
        if (!reach)
          data_q <= req_write_i ? '0 : size_mask(req_size_i);
        else
          data_q <= req_wdata_i;
        if (reach) begin
          type_q <= route_type;
          if (!is_local) target_q <= route_target;
        end
      end
      if (state == ST_RD && mem_ack_i)
        data_q <= wr_q ? lane_merged : lane_extract;
    end
  end

  assign req_ready_o  = seq_ready;
  assign rsp_valid_o  = seq_rsp;
  assign rsp_rdata_o  = (seq_rsp && !wr_q) ? data_q : '0;
  assign mem_req_o    = seq_req;
  assign mem_we_o     = seq_we;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = seq_we ? data_q : '0;
  assign win_type_o   = type_q;
  assign win_target_o = target_q;

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_W-1:0]  root_bus_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [BUS_W-1:0]  req_bus_i,
  input logic [DEV_W-1:0]  req_dev_i,
  input logic              rsp_valid_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic [2:0]        win_type_o,
  input logic [31:0]       win_target_o
);
  logic root_drop;
  assign root_drop = req_valid_i && req_ready_o && (req_bus_i == root_bus_i) && (req_dev_i != '0);

  p_drop_root_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    root_drop |=> (!mem_req_o && rsp_valid_o && $stable(win_type_o) && $stable(win_target_o)));

  p_type_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_type_o == 3'd4) || (win_type_o == 3'd5));

  p_target_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_target_o[15:0] == 16'h0);

  p_word_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  p_rsp_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_hold_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

endmodule

bind cfg_xlate cfg_xlate_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .root_bus_i   (root_bus_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_bus_i    (req_bus_i),
  .req_dev_i    (req_dev_i),
  .rsp_valid_o  (rsp_valid_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .win_type_o   (win_type_o),
  .win_target_o (win_target_o)
);

// File: tb/cfg_xlate_test.sv
module cfg_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LBASE = 32'h1000_0000;
  localparam logic [31:0] WBASE = 32'h2000_0000;
  localparam logic [31:0] INIT  = 32'h4433_2211;

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
    logic [1:0]  sz;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [2:0]  typ;
    logic [31:0] tgt;
    logic [1:0]  nrd;
    logic [1:0]  nwr;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 14;
  // root bus is 2 for the table
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd2, 5'd0,  3'd0, 12'h008, 2'd2, 32'h0,        32'h4433_2211, 3'd5, 32'h0000_0000, 2'd1, 2'd0, 32'h1000_0008},
    '{1'b0, 8'd3, 5'd0,  3'd1, 12'h00D, 2'd0, 32'h0,        32'h0000_0022, 3'd4, 32'h0301_0000, 2'd1, 2'd0, 32'h2000_000C},
    '{1'b0, 8'd5, 5'd7,  3'd2, 12'h012, 2'd1, 32'h0,        32'h0000_4433, 3'd5, 32'h053A_0000, 2'd1, 2'd0, 32'h2000_0010},
    '{1'b1, 8'd3, 5'd0,  3'd0, 12'h021, 2'd0, 32'h0000_00AB, 32'h0,        3'd4, 32'h0300_0000, 2'd1, 2'd1, 32'h2000_0020},
    '{1'b0, 8'd3, 5'd0,  3'd0, 12'h020, 2'd2, 32'h0,        32'h4433_AB11, 3'd4, 32'h0300_0000, 2'd1, 2'd0, 32'h2000_0020},
    '{1'b1, 8'd2, 5'd0,  3'd0, 12'h032, 2'd1, 32'h0000_BEEF, 32'h0,        3'd5, 32'h0300_0000, 2'd1, 2'd1, 32'h1000_0030},
    '{1'b0, 8'd2, 5'd0,  3'd0, 12'h030, 2'd2, 32'h0,        32'hBEEF_2211, 3'd5, 32'h0300_0000, 2'd1, 2'd0, 32'h1000_0030},
    '{1'b1, 8'd9, 5'd3,  3'd7, 12'h044, 2'd2, 32'hCAFE_F00D, 32'h0,        3'd5, 32'h091F_0000, 2'd0, 2'd1, 32'h2000_0044},
    '{1'b0, 8'd9, 5'd3,  3'd7, 12'h047, 2'd0, 32'h0,        32'h0000_00CA, 3'd5, 32'h091F_0000, 2'd1, 2'd0, 32'h2000_0044},
    '{1'b0, 8'd2, 5'd1,  3'd0, 12'h044, 2'd1, 32'h0,        32'h0000_FFFF, 3'd5, 32'h091F_0000, 2'd0, 2'd0, 32'h0},
    '{1'b1, 8'd3, 5'd4,  3'd0, 12'h044, 2'd2, 32'h1234_5678, 32'h0,        3'd5, 32'h091F_0000, 2'd0, 2'd0, 32'h0},
    '{1'b0, 8'd9, 5'd3,  3'd7, 12'h044, 2'd2, 32'h0,        32'hCAFE_F00D, 3'd5, 32'h091F_0000, 2'd1, 2'd0, 32'h2000_0044},
    '{1'b0, 8'd3, 5'd31, 3'd0, 12'h000, 2'd0, 32'h0,        32'h0000_00FF, 3'd5, 32'h091F_0000, 2'd0, 2'd0, 32'h0},
    '{1'b0, 8'd3, 5'd0,  3'd0, 12'h047, 2'd0, 32'h0,        32'h0000_00CA, 3'd4, 32'h0300_0000, 2'd1, 2'd0, 32'h2000_0044}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  root_bus = 8'd2;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  win_type;
  logic [31:0] win_target;

  logic [31:0] mem [64];
  int          tot_rd = 0, tot_wr = 0;
  logic [31:0] last_addr = '0;
  int          n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .root_bus_i(root_bus),
    .local_base_i(LBASE), .window_base_i(WBASE),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bus_i(req_bus), .req_dev_i(req_dev), .req_fn_i(req_fn),
    .req_off_i(req_off), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .win_type_o(win_type), .win_target_o(win_target)
  );

  function automatic int midx(input logic [31:0] a);
    return int'({a[29], a[6:2]});
  endfunction

  assign mem_rdata = mem_ack ? mem[midx(mem_addr)] : 32'h0;

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_ack) begin
      last_addr <= mem_addr;
      if (mem_we) begin
        mem[midx(mem_addr)] <= mem_wdata;
        tot_wr <= tot_wr + 1;
      end else begin
        tot_rd <= tot_rd + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input string tag);
    int rd0, wr0, busy_bad;
    rd0 = tot_rd; wr0 = tot_wr; busy_bad = 0;
    @(negedge clk);
    req_write = v.wr; req_bus = v.bus; req_dev = v.dev; req_fn = v.fn;
    req_off = v.off; req_size = v.sz; req_wdata = v.wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
    end
    check(busy_bad == 0 && !req_ready, {tag, " R9 ready low while busy"}, 32'(busy_bad), 32'h0);
    check(rsp_rdata == v.rdata, {tag, " R8 R1 response data"}, rsp_rdata, v.rdata);
    check(win_type == v.typ, {tag, " R3 type code"}, 32'(win_type), 32'(v.typ));
    check(win_target == v.tgt, {tag, " R5 R4 translation target"}, win_target, v.tgt);
    check(tot_rd - rd0 == int'(v.nrd), {tag, " R7 R1 R2 read count"}, 32'(tot_rd - rd0), 32'(v.nrd));
    check(tot_wr - wr0 == int'(v.nwr), {tag, " R7 R1 R2 write count"}, 32'(tot_wr - wr0), 32'(v.nwr));
    if (v.nrd + v.nwr != 0)
      check(last_addr == v.addr, {tag, " R4 R5 R6 address"}, last_addr, v.addr);
    @(negedge clk);
    check(!rsp_valid && req_ready, {tag, " R9 single response pulse"}, 32'({rsp_valid, req_ready}), 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = INIT;
    repeat (3) @(negedge clk);
    check(req_ready && !mem_req && !rsp_valid, "R10 reset handshake", 32'({req_ready, mem_req, rsp_valid}), 32'h4);
    check(win_type == 3'd4, "R10 R3 reset type", 32'(win_type), 32'd4);
    check(win_target == 32'h0, "R10 reset target", win_target, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req, "R10 idle after reset", 32'({req_ready, mem_req}), 32'h2);

    for (int i = 0; i < NV; i++) run(VEC[i], $sformatf("vec%0d", i));

    // root bus 255: no neighbour bus, bus 0 with a nonzero device stays reachable (R2)
    root_bus = 8'hFF;
    run('{1'b0, 8'd0, 5'd1, 3'd0, 12'h000, 2'd2, 32'h0, INIT, 3'd5, 32'h0008_0000, 2'd1, 2'd0, 32'h2000_0000}, "R2 root 255 no wrap");
    // root bus 255 itself with device 0 goes local (R4)
    run('{1'b0, 8'hFF, 5'd0, 3'd0, 12'h010, 2'd2, 32'h0, INIT, 3'd5, 32'h0008_0000, 2'd1, 2'd0, 32'h1000_0010}, "R4 root 255 local");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule